// File: doc/BRIEF.md
# Supervisor Virtual Interrupt CSR Unit

This block keeps the machine-level virtual interrupt enable and virtual interrupt pending registers for 64 interrupt numbers. It also serves the supervisor interrupt-enable and interrupt-pending views of those numbers. Machine firmware uses it to stop delegating an interrupt, take it itself, and then inject a supervisor interrupt on its own terms. Firmware may also inject supervisor interrupts that have no hardware source at all.

Every access is a read-modify-write. It carries a selector, write data and a write mask, and it returns the old value one cycle later. For each bit, the machine delegation bit and the virtual-enable bit decide how each view behaves. A view bit may alias the machine register, which the block forwards as a masked write strobe. It may instead live in the block's own storage, or it may read as zero. The unit also decides whether supervisor accesses to the external interrupt controller are forwarded or suppressed. On a 32-bit build, the upper halves of the two virtual registers are reached through separate selectors.

Top module: `svi_csr_unit`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `rd_valid`, `ext_fwd` and all strobes are zero. All block-held storage bits reset to zero.
- R2: The virtual-enable register (selector 0) holds only bits 1, 9 and 13..63, with writable mask 64'hFFFF_FFFF_FFFF_E202. All other bits read zero.
- R3: In the virtual-pending register (selector 2), a bit with delegation 0 and virtual-enable 1 is held in the block's own storage and raises no machine-pending strobe. Only bits 1, 5, 9 and 13..63 can be written.
- R4: A virtual-pending bit whose delegation is 1 or whose virtual-enable is 0 reads the machine-pending input. Writing it drives `mpend_wmask`/`mpend_wdata` in the next cycle and leaves block storage unchanged.
- R5: Virtual-pending bit 5 aliases machine-pending bit 5. The alias is cut, so the bit reads zero and raises no strobe, when `tmr_cmp_en` is 1 and `priv` is machine (3).
- R6: In the supervisor pending view (selector 5), a bit with delegation 0 and virtual-enable 0 reads zero and ignores writes. With virtual-enable 1 only, it aliases the virtual-pending storage. With delegation 1, it aliases machine-pending. Only bits 1 and 13..63 are writable through this view.
- R7: In the supervisor enable view (selector 4), a bit reads zero when delegation and virtual-enable are both 0. With virtual-enable 1 only, it is a separate writable storage bit. With delegation 1, it aliases machine-enable, and writes to it are forwarded on `men_wmask`/`men_wdata`.
- R8: When XLEN is 32, selectors 1 and 3 reach bits 63..32 of the virtual-enable and virtual-pending registers. Write data and mask are shifted up by 32 and read data down by 32. Selectors 0 and 2 reach bits 31..0.
- R9: Selector 6 (top external interrupt) and selector 7 (indirect access) raise `ext_fwd` in the next cycle. They do not raise it when `priv` is supervisor (1) and virtual-enable bit 9 is set, for selector 6 always and for selector 7 when `ind_sel` is within 12'h070..12'h0FF.
- R10: An access returns the old value of the selected view in `rd_data` one cycle later. Only bits set in both the write mask and the view's writable mask change. With no access, storage holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access request this cycle |
| acc_sel | input | 3 | View selector: 0 venable, 1 venable high, 2 vpending, 3 vpending high, 4 s-enable, 5 s-pending, 6 top external, 7 indirect |
| acc_wdata | input | XLEN | Write data |
| acc_wmask | input | XLEN | Per-bit write mask |
| priv | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| tmr_cmp_en | input | 1 | Timer-compare extension enabled |
| ind_sel | input | ISEL_W | Indirect register selector |
| deleg | input | 64 | Machine delegation vector |
| m_en | input | 64 | Machine interrupt-enable vector |
| m_pend | input | 64 | Machine interrupt-pending vector |
| rd_valid | output | 1 | Read data valid, one cycle after access |
| rd_data | output | XLEN | Old value of the selected view |
| ext_fwd | output | 1 | External-controller access forwarded |
| mpend_wmask | output | 64 | Write strobe mask into machine-pending |
| mpend_wdata | output | 64 | Write data into machine-pending |
| men_wmask | output | 64 | Write strobe mask into machine-enable |
| men_wdata | output | 64 | Write data into machine-enable |

## Verification
The assertions assume that `deleg`, `m_en`, `m_pend`, `priv` and `tmr_cmp_en` hold steady across each access. They also assume `priv` carries only the codes 0, 1 and 3. The bench changes these vectors only between accesses, and it drives every input a nanosecond after a rising edge. It starts the run with reset high, so the storage and strobe properties begin from a known state. It uses the high-half selectors only on the 32-bit instance.

// File: rtl/svi_pkg.sv
package svi_pkg;
  localparam int NIRQ = 64;

  typedef enum logic [2:0] {
    SEL_VEN    = 3'd0,
    SEL_VEN_HI = 3'd1,
    SEL_VP     = 3'd2,
    SEL_VP_HI  = 3'd3,
    SEL_SIE    = 3'd4,
    SEL_SIP    = 3'd5,
    SEL_TOPEI  = 3'd6,
    SEL_IREG   = 3'd7
  } sel_e;

  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;

  localparam int TMR_BIT = 5;
  localparam int EXT_BIT = 9;

  // supervisor-level interrupt numbers: 1, 5, 9 and 13..63
  localparam logic [NIRQ-1:0] S_SET     = 64'hFFFF_FFFF_FFFF_E222;
  localparam logic [NIRQ-1:0] VEN_WMASK = 64'hFFFF_FFFF_FFFF_E202;
  localparam logic [NIRQ-1:0] VP_WMASK  = 64'hFFFF_FFFF_FFFF_E222;
  localparam logic [NIRQ-1:0] SIP_WMASK = 64'hFFFF_FFFF_FFFF_E002;
endpackage

// File: rtl/svi_view_masks.sv
module svi_view_masks
  import svi_pkg::*;
(
  input  logic [NIRQ-1:0] deleg,
  input  logic [NIRQ-1:0] ven,
  input  logic            cut_tmr,
  output logic [NIRQ-1:0] vp_alias,
  output logic [NIRQ-1:0] own,
  output logic [NIRQ-1:0] sip_alias,
  output logic [NIRQ-1:0] sie_alias
);
  logic [NIRQ-1:0] tmr_cut_vec;

  always_comb begin
    tmr_cut_vec          = '0;
    tmr_cut_vec[TMR_BIT] = cut_tmr;
    // bits that come from the machine-pending vector
    vp_alias  = S_SET & (deleg | ~ven) & ~tmr_cut_vec;
    // bits held in the block: not delegated, virtually enabled
    own       = S_SET & ~deleg & ven;
    // supervisor pending view drops bits that neither delegate nor virtualize
    sip_alias = vp_alias & (deleg | ven);
    sie_alias = S_SET & deleg;
  end
endmodule

// File: rtl/svi_bitreg.sv
module svi_bitreg #(
  parameter int              W        = 64,
  parameter logic [W-1:0]    WRITABLE = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] upd_mask,
  input  logic [W-1:0] upd_data,
  output logic [W-1:0] q
);
  logic [W-1:0] eff_mask;

  assign eff_mask = upd_mask & WRITABLE;

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= (q & ~eff_mask) | (upd_data & eff_mask);
  end
endmodule

// File: rtl/svi_width_adapt.sv
module svi_width_adapt #(
  parameter int XLEN = 64,
  parameter int NW   = 64
) (
  input  logic            is_hi,
  input  logic [XLEN-1:0] wdata,
  input  logic [XLEN-1:0] wmask,
  output logic [NW-1:0]   wd_w,
  output logic [NW-1:0]   wm_w,
  input  logic [NW-1:0]   rd_w,
  output logic [XLEN-1:0] rd_n
);
  localparam int PAD = NW - XLEN;

  generate
    if (XLEN < NW) begin : g_narrow
      assign wd_w = is_hi ? {wdata, {PAD{1'b0}}} : {{PAD{1'b0}}, wdata};
      assign wm_w = is_hi ? {wmask, {PAD{1'b0}}} : {{PAD{1'b0}}, wmask};
      assign rd_n = is_hi ? rd_w[NW-1:PAD] : rd_w[XLEN-1:0];
    end else begin : g_full
      assign wd_w = wdata;
      assign wm_w = is_hi ? '0 : wmask;
      assign rd_n = is_hi ? '0 : rd_w;
    end
  endgenerate
endmodule

// File: rtl/svi_ext_gate.sv
module svi_ext_gate #(
  parameter int              ISEL_W = 12,
  parameter logic [ISEL_W-1:0] LO   = 12'h070,
  parameter logic [ISEL_W-1:0] HI   = 12'h0FF
) (
  input  logic              is_topei,
  input  logic              is_ireg,
  input  logic [ISEL_W-1:0] ind_sel,
  input  logic              ven_ext,
  input  logic              priv_s,
  output logic              fwd
);
  logic in_rng;
  logic block;

  assign in_rng = (ind_sel >= LO) && (ind_sel <= HI);
  assign block  = ven_ext && priv_s && (is_topei || (is_ireg && in_rng));
  assign fwd    = (is_topei || is_ireg) && !block;
endmodule

// File: rtl/svi_csr_unit.sv
module svi_csr_unit
  import svi_pkg::*;
#(
  parameter int                XLEN        = 64,
  parameter int                ISEL_W      = 12,
  parameter logic [ISEL_W-1:0] EXT_ISEL_LO = 12'h070,
  parameter logic [ISEL_W-1:0] EXT_ISEL_HI = 12'h0FF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_valid,
  input  logic [2:0]        acc_sel,
  input  logic [XLEN-1:0]   acc_wdata,
  input  logic [XLEN-1:0]   acc_wmask,
  input  logic [1:0]        priv,
  input  logic              tmr_cmp_en,
  input  logic [ISEL_W-1:0] ind_sel,
  input  logic [NIRQ-1:0]   deleg,
  input  logic [NIRQ-1:0]   m_en,
  input  logic [NIRQ-1:0]   m_pend,
  output logic              rd_valid,
  output logic [XLEN-1:0]   rd_data,
  output logic              ext_fwd,
  output logic [NIRQ-1:0]   mpend_wmask,
  output logic [NIRQ-1:0]   mpend_wdata,
  output logic [NIRQ-1:0]   men_wmask,
  output logic [NIRQ-1:0]   men_wdata
);
  localparam bit HAS_HI = (XLEN < NIRQ);

  sel_e            sel;
  logic            is_hi, ven_acc, vp_acc, sie_acc, sip_acc;
  logic [NIRQ-1:0] wd_w, wm_w, rd_w;
  logic [XLEN-1:0] rd_n;
  logic [NIRQ-1:0] ven_q, vp_q, sie_q;
  logic [NIRQ-1:0] vp_alias, own, sip_alias, sie_alias;
  logic [NIRQ-1:0] ven_upd, vp_upd, sie_upd, pend_stb, en_stb;
  logic            cut_tmr, fwd;

  // selector decode
  always_comb begin
    sel     = sel_e'(acc_sel);
    is_hi   = HAS_HI && (sel == SEL_VEN_HI || sel == SEL_VP_HI);
    ven_acc = acc_valid && (sel == SEL_VEN || (HAS_HI && sel == SEL_VEN_HI));
    vp_acc  = acc_valid && (sel == SEL_VP  || (HAS_HI && sel == SEL_VP_HI));
    sie_acc = acc_valid && (sel == SEL_SIE);
    sip_acc = acc_valid && (sel == SEL_SIP);
    cut_tmr = tmr_cmp_en && (priv == PRIV_M);
  end

  svi_width_adapt #(.XLEN(XLEN), .NW(NIRQ)) u_adapt (
    .is_hi (is_hi),
    .wdata (acc_wdata),
    .wmask (acc_wmask),
    .wd_w  (wd_w),
    .wm_w  (wm_w),
    .rd_w  (rd_w),
    .rd_n  (rd_n)
  );

  svi_view_masks u_masks (
    .deleg     (deleg),
    .ven       (ven_q),
    .cut_tmr   (cut_tmr),
    .vp_alias  (vp_alias),
    .own       (own),
    .sip_alias (sip_alias),
    .sie_alias (sie_alias)
  );

  // old value of the selected view
  always_comb begin
    unique case (sel)
      SEL_VEN, SEL_VEN_HI: rd_w = ven_q;
      SEL_VP,  SEL_VP_HI:  rd_w = (m_pend & vp_alias) | (vp_q & own);
      SEL_SIE:             rd_w = (m_en & sie_alias) | (sie_q & own);
      SEL_SIP:             rd_w = (m_pend & sip_alias) | (vp_q & own);
      default:             rd_w = '0;
    endcase
  end

  // update and forwarding masks
  always_comb begin
    ven_upd  = ven_acc ? wm_w : '0;
    vp_upd   = '0;
    pend_stb = '0;
    if (vp_acc) begin
      vp_upd   = wm_w & own;
      pend_stb = wm_w & vp_alias & VP_WMASK;
    end else if (sip_acc) begin
      vp_upd   = wm_w & own & SIP_WMASK;
      pend_stb = wm_w & sip_alias & SIP_WMASK;
    end
    sie_upd = sie_acc ? (wm_w & own) : '0;
    en_stb  = sie_acc ? (wm_w & sie_alias) : '0;
  end

  svi_bitreg #(.W(NIRQ), .WRITABLE(VEN_WMASK)) u_ven (
    .clk (clk), .rst (rst), .upd_mask (ven_upd), .upd_data (wd_w), .q (ven_q)
  );

  svi_bitreg #(.W(NIRQ), .WRITABLE(VP_WMASK)) u_vp (
    .clk (clk), .rst (rst), .upd_mask (vp_upd), .upd_data (wd_w), .q (vp_q)
  );

  svi_bitreg #(.W(NIRQ), .WRITABLE(S_SET)) u_sie (
    .clk (clk), .rst (rst), .upd_mask (sie_upd), .upd_data (wd_w), .q (sie_q)
  );

  svi_ext_gate #(.ISEL_W(ISEL_W), .LO(EXT_ISEL_LO), .HI(EXT_ISEL_HI)) u_gate (
    .is_topei (acc_valid && sel == SEL_TOPEI),
    .is_ireg  (acc_valid && sel == SEL_IREG),
    .ind_sel  (ind_sel),
    .ven_ext  (ven_q[EXT_BIT]),
    .priv_s   (priv == PRIV_S),
    .fwd      (fwd)
  );

  // registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid    <= 1'b0;
      rd_data     <= '0;
      ext_fwd     <= 1'b0;
      mpend_wmask <= '0;
      mpend_wdata <= '0;
      men_wmask   <= '0;
      men_wdata   <= '0;
    end else begin
      rd_valid    <= acc_valid;
      rd_data     <= acc_valid ? rd_n : '0;
      ext_fwd     <= fwd;
      mpend_wmask <= pend_stb;
      mpend_wdata <= wd_w & pend_stb;
      men_wmask   <= en_stb;
      men_wdata   <= wd_w & en_stb;
    end
  end
endmodule

// File: rtl/svi_csr_unit_chk.sv
module svi_csr_unit_chk
  import svi_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic            acc_valid,
  input logic [2:0]      acc_sel,
  input logic [1:0]      priv,
  input logic            tmr_cmp_en,
  input logic [NIRQ-1:0] ven_q,
  input logic [NIRQ-1:0] vp_q,
  input logic [NIRQ-1:0] sie_q,
  input logic            rd_valid,
  input logic            ext_fwd,
  input logic [NIRQ-1:0] mpend_wmask,
  input logic [NIRQ-1:0] men_wmask
);
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!rd_valid && !ext_fwd && mpend_wmask == '0 && men_wmask == '0)); // R1

  AST_VEN_LEGAL: assert property (@(posedge clk) disable iff (rst)
    (ven_q & ~VEN_WMASK) == '0); // R2

  AST_VP_LEGAL: assert property (@(posedge clk) disable iff (rst)
    ((vp_q & ~VP_WMASK) == '0) && ((mpend_wmask & ~VP_WMASK) == '0)); // R3

  AST_STROBE_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> (mpend_wmask == '0 && men_wmask == '0)); // R4

  AST_TIMER_CUT: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_sel == SEL_VP && priv == PRIV_M && tmr_cmp_en)
      |=> !mpend_wmask[TMR_BIT]); // R5

  AST_SIP_WMASK: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_sel == SEL_SIP) |=> ((mpend_wmask & ~SIP_WMASK) == '0)); // R6

  AST_SIE_NO_PEND: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_sel == SEL_SIE) |=> (mpend_wmask == '0)); // R7

  AST_EXT_BLOCK: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_sel == SEL_TOPEI && priv == PRIV_S && ven_q[EXT_BIT])
      |=> !ext_fwd); // R9

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> ($stable(ven_q) && $stable(vp_q) && $stable(sie_q))); // R10
endmodule

bind svi_csr_unit svi_csr_unit_chk u_chk (.*);

// File: tb/svi_csr_unit_test.sv
`timescale 1ns/1ps
module svi_csr_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        av = 1'b0, av32 = 1'b0;
  logic [2:0]  sel = '0, sel32 = '0;
  logic [63:0] wd = '0, wm = '0;
  logic [31:0] wd32 = '0, wm32 = '0;
  logic [1:0]  priv = 2'd3;
  logic        tce = 1'b0;
  logic [11:0] isel = '0;
  logic [63:0] deleg = '0, men = '0, mpend = '0;
  logic        rv, xf, rv32, xf32;
  logic [63:0] rd, pwm, pwd, ewm, ewd;
  logic [31:0] rd32;
  logic [63:0] pwm32, pwd32, ewm32, ewd32;
  int          nchk = 0, nerr = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  svi_csr_unit uut (
    .clk(clk), .rst(rst), .acc_valid(av), .acc_sel(sel), .acc_wdata(wd),
    .acc_wmask(wm), .priv(priv), .tmr_cmp_en(tce), .ind_sel(isel),
    .deleg(deleg), .m_en(men), .m_pend(mpend), .rd_valid(rv), .rd_data(rd),
    .ext_fwd(xf), .mpend_wmask(pwm), .mpend_wdata(pwd), .men_wmask(ewm),
    .men_wdata(ewd)
  );

  svi_csr_unit #(.XLEN(32)) uut32 (
    .clk(clk), .rst(rst), .acc_valid(av32), .acc_sel(sel32), .acc_wdata(wd32),
    .acc_wmask(wm32), .priv(priv), .tmr_cmp_en(tce), .ind_sel(isel),
    .deleg(deleg), .m_en(men), .m_pend(mpend), .rd_valid(rv32), .rd_data(rd32),
    .ext_fwd(xf32), .mpend_wmask(pwm32), .mpend_wdata(pwd32), .men_wmask(ewm32),
    .men_wdata(ewd32)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic acc(input logic [2:0] s, input logic [63:0] d, input logic [63:0] m);
    sel = s; wd = d; wm = m; av = 1'b1;
    @(posedge clk); #1;
    av = 1'b0; wm = '0;
  endtask

  task automatic acc32(input logic [2:0] s, input logic [31:0] d, input logic [31:0] m);
    sel32 = s; wd32 = d; wm32 = m; av32 = 1'b1;
    @(posedge clk); #1;
    av32 = 1'b0; wm32 = '0;
  endtask

  task automatic t_reset;
    chk("R1 rd_valid", {63'b0, rv}, 64'd0);
    chk("R1 strobes", pwm | ewm, 64'd0);
    chk("R1 ext_fwd", {63'b0, xf}, 64'd0);
    acc(3'd0, 64'd0, 64'd0);
    chk("R1 venable reset", rd, 64'd0);
    acc(3'd2, 64'd0, 64'd0);
    chk("R1 vpending reset", rd, 64'd0);
  endtask

  task automatic t_venable;
    acc(3'd0, '1, '1);
    chk("R10 old value", rd, 64'd0);
    acc(3'd0, 64'd0, 64'd0);
    chk("R2 writable bits", rd, 64'hFFFF_FFFF_FFFF_E202);
    acc(3'd0, 64'd0, 64'h200);
    acc(3'd0, 64'd0, 64'd0);
    chk("R10 masked write", rd, 64'hFFFF_FFFF_FFFF_E002);
  endtask

  task automatic t_vpend_own;
    priv = 2'd3; tce = 1'b0; deleg = '0; mpend = '0;
    acc(3'd2, '1, '1);
    chk("R3 old value", rd, 64'd0);
    chk("R4 alias strobe mask", pwm, 64'h220);
    chk("R4 alias strobe data", pwd, 64'h220);
    mpend = 64'h220;
    acc(3'd2, 64'd0, 64'd0);
    chk("R3 own plus alias", rd, 64'hFFFF_FFFF_FFFF_E222);
    chk("R3 read no strobe", pwm, 64'd0);
  endtask

  task automatic t_deleg_alias;
    deleg = 64'h2000; mpend = '0;
    acc(3'd2, 64'd0, 64'd0);
    chk("R4 delegated reads m_pend", rd, 64'hFFFF_FFFF_FFFF_C002);
  endtask

  task automatic t_timer;
    tce = 1'b1; priv = 2'd3; mpend = 64'h20;
    acc(3'd2, 64'd0, 64'd0);
    chk("R5 cut reads zero", rd, 64'hFFFF_FFFF_FFFF_C002);
    acc(3'd2, 64'h20, 64'h20);
    chk("R5 cut no strobe", pwm, 64'd0);
    priv = 2'd1;
    acc(3'd2, 64'd0, 64'd0);
    chk("R5 supervisor keeps alias", rd, 64'hFFFF_FFFF_FFFF_C022);
    tce = 1'b0; priv = 2'd3;
  endtask

  task automatic t_sip;
    priv = 2'd1; mpend = 64'h222;
    acc(3'd5, 64'd0, 64'd0);
    chk("R6 sip view", rd, 64'hFFFF_FFFF_FFFF_C002);
    acc(3'd5, 64'd0, '1);
    chk("R6 sip strobe only bit13", pwm, 64'h2000);
    priv = 2'd3;
    acc(3'd2, 64'd0, 64'd0);
    chk("R6 sip write reached storage", rd, 64'h220);
  endtask

  task automatic t_sie;
    priv = 2'd1; men = 64'h2200;
    acc(3'd4, 64'd0, 64'd0);
    chk("R7 sie view", rd, 64'h2000);
    acc(3'd4, '1, '1);
    chk("R7 enable strobe", ewm, 64'h2000);
    chk("R7 enable data", ewd, 64'h2000);
    chk("R7 no pend strobe", pwm, 64'd0);
    acc(3'd4, 64'd0, 64'd0);
    chk("R7 sie own storage", rd, 64'hFFFF_FFFF_FFFF_E002);
  endtask

  task automatic t_ext;
    acc(3'd0, 64'h200, 64'h200);
    priv = 2'd1;
    acc(3'd6, 64'd0, 64'd0);
    chk("R9 topei blocked", {63'b0, xf}, 64'd0);
    priv = 2'd3;
    acc(3'd6, 64'd0, 64'd0);
    chk("R9 topei machine fwd", {63'b0, xf}, 64'd1);
    priv = 2'd1; isel = 12'h080;
    acc(3'd7, 64'd0, 64'd0);
    chk("R9 ireg in range blocked", {63'b0, xf}, 64'd0);
    isel = 12'h030;
    acc(3'd7, 64'd0, 64'd0);
    chk("R9 ireg out of range fwd", {63'b0, xf}, 64'd1);
    acc(3'd0, 64'd0, 64'h200);
    acc(3'd6, 64'd0, 64'd0);
    chk("R9 topei fwd when bit9 clear", {63'b0, xf}, 64'd1);
    priv = 2'd3;
  endtask

  task automatic t_rv32;
    acc32(3'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    acc32(3'd1, 32'd0, 32'd0);
    chk("R8 venable high", {32'b0, rd32}, 64'hFFFF_FFFF);
    acc32(3'd0, 32'd0, 32'd0);
    chk("R8 venable low untouched", {32'b0, rd32}, 64'd0);
    acc32(3'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    acc32(3'd0, 32'd0, 32'd0);
    chk("R8 venable low", {32'b0, rd32}, 64'hFFFF_E202);
    acc32(3'd3, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    chk("R8 vpending high no strobe", pwm32, 64'd0);
    acc32(3'd3, 32'd0, 32'd0);
    chk("R8 vpending high", {32'b0, rd32}, 64'hFFFF_FFFF);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(posedge clk); #1;
    t_reset;
    t_venable;
    t_vpend_own;
    t_deleg_alias;
    t_timer;
    t_sip;
    t_sie;
    t_ext;
    t_rv32;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end
endmodule